// File: doc/BRIEF.md
# Redundant Load Predictor

This block guesses, for each load, whether the value memory will return matches the value already held in the load's destination register. When it guesses yes, the pipeline can let dependent instructions continue on the old register contents and skip waiting for the load. The guess comes from a table of small saturating counters. The table is indexed by the address of the load instruction itself, not by the data address the load reads.

A predict port takes the instruction address and a cache-hit flag and returns a guess in the same cycle. A guess of redundant is only ever given on a cache hit.

Later, a resolve port takes four things: the instruction address, the value actually loaded, the register's previous value, and the guess that was made. The block trains the counter with the real outcome. In the same cycle it pulses a flush request if a guess of redundant turned out wrong. It also keeps three running statistics.

Top module: `load_reuse_predictor`

## Requirements
- R1: The table has ENTRIES counters (default 64). The counter used by an access is selected by instruction-address bits [log2(ENTRIES)+1:2]. Two addresses that agree in those bits share one counter.
- R2: After reset, every counter holds 1 (weakly not redundant), and all three statistics read 0.
- R3: A resolve moves its counter. The counter goes up by one, stopping at 3, when the loaded value equals the previous register value. Otherwise it goes down by one, stopping at 0.
- R4: While the predict port reports a cache miss, predRedundant is 0 whatever the counter holds.
- R5: With predValid and predHit both high, predRedundant is 1 exactly when the selected counter is 2 or 3. It is combinational in the same cycle. With predValid low, predRedundant is 0.
- R6: flushReq is 1, in the cycle the resolve is presented, exactly when resValid is high, resPredicted is high and the two values differ. A resolve that was guessed not redundant never flushes.
- R7: Each resolve updates the statistics, visible after the next rising edge. statLoads rises by one. statRedundant rises by one when the values matched. statMispredict rises by one when resPredicted disagrees with the outcome, in either direction.
- R8: Each statistic is STAT_W bits wide (default 32) and holds at its all-ones value instead of wrapping.
- R9: If a predict and a resolve select the same counter in one cycle, the predict sees the counter value from before that cycle's update.
- R10: While resValid is low, neither the counters nor the statistics change, whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| predValid | input | 1 | A load is asking for a guess |
| predPc | input | PC_W | Instruction address of the asking load |
| predHit | input | 1 | The load's cache access hit |
| predRedundant | output | 1 | Guess: value will match the register |
| resValid | input | 1 | A load outcome is presented |
| resPc | input | PC_W | Instruction address of the resolving load |
| resLoadVal | input | DATA_W | Value returned from memory |
| resOldVal | input | DATA_W | Destination register value before the load |
| resPredicted | input | 1 | Guess that was made for this load |
| flushReq | output | 1 | Wrong redundant guess; restore saved state |
| statLoads | output | STAT_W | Resolved loads |
| statRedundant | output | STAT_W | Loads whose value matched |
| statMispredict | output | STAT_W | Loads whose guess was wrong |

## Verification
predRedundant and flushReq are combinational, so each is due in the same cycle its inputs are driven. Counter training and statistics are registered, so they show their effect only after the following rising edge. The bench drives inputs at the falling edge and compares the combinational outputs a quarter period later against a behavioural model. It advances the model only after the rising edge. The statistics check in the next cycle therefore sees exactly one update per resolve.

// File: rtl/lrp_pkg.sv
package lrp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic train;          // move the counter of the resolving load
    logic up;             // direction when training
    logic bumpLoads;
    logic bumpRedundant;
    logic bumpMiss;
  } lrpStrobe_t;
endpackage

// File: rtl/lrp_satcount.sv
module lrp_satcount #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (bump && count != TOP) count <= count + 1'b1;
  end

  // R8: holds at all ones
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && count == TOP) |=> count == TOP);
  // R7: one step per bump
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && count != TOP) |=> count == $past(count) + 1'b1);
  // R10: idle means no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(count));
endmodule

// File: rtl/lrp_ctrl.sv
module lrp_ctrl
  import lrp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       predValid,
  input  logic       predHit,
  input  logic       predCtrMsb,
  input  logic       resValid,
  input  logic       resPredicted,
  input  logic       valueMatch,
  output logic       predRedundant,
  output logic       flushReq,
  output lrpStrobe_t strobe
);
  always_comb begin
    predRedundant = predValid && predHit && predCtrMsb;
    flushReq      = resValid && resPredicted && !valueMatch;
    strobe.train         = resValid;
    strobe.up            = valueMatch;
    strobe.bumpLoads     = resValid;
    strobe.bumpRedundant = resValid && valueMatch;
    strobe.bumpMiss      = resValid && (resPredicted != valueMatch);
  end

  // R4: a miss never yields a redundant guess
  a_r4_miss_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (predValid && !predHit) |-> !predRedundant);
  // R6: flush only follows a redundant guess
  a_r6_flush_source: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |-> (resValid && resPredicted));
  // R6/R7: every flush is also counted as a mispredict
  a_r7_flush_counted: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |-> strobe.bumpMiss);
  // R10: idle resolve port issues no strobes
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |-> (strobe.train == 1'b0 && strobe.bumpLoads == 1'b0 &&
                   strobe.bumpRedundant == 1'b0 && strobe.bumpMiss == 1'b0));
endmodule

// File: rtl/lrp_datapath.sv
module lrp_datapath
  import lrp_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  parameter int DATA_W  = 32,
  parameter int STAT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   predPc,
  input  logic [PC_W-1:0]   resPc,
  input  logic [DATA_W-1:0] resLoadVal,
  input  logic [DATA_W-1:0] resOldVal,
  input  lrpStrobe_t        strobe,
  output logic              predCtrMsb,
  output logic              valueMatch,
  output logic [STAT_W-1:0] statLoads,
  output logic [STAT_W-1:0] statRedundant,
  output logic [STAT_W-1:0] statMispredict
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] predIdx, resIdx;
  logic [1:0]       ctrTable [ENTRIES];

  assign predIdx    = predPc[IDX_W+1:2];
  assign resIdx     = resPc[IDX_W+1:2];
  assign valueMatch = (resLoadVal == resOldVal);
  assign predCtrMsb = ctrTable[predIdx][1];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ctr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrTable[i] <= 2'b01;
      else if (strobe.train && resIdx == IDX_W'(i)) begin
        if (strobe.up) ctrTable[i] <= (ctrTable[i] == 2'b11) ? 2'b11 : ctrTable[i] + 2'b01;
        else           ctrTable[i] <= (ctrTable[i] == 2'b00) ? 2'b00 : ctrTable[i] - 2'b01;
      end
    end
  end

  lrp_satcount #(.W(STAT_W)) uLoads (.clk(clk), .rst_n(rst_n),
    .bump(strobe.bumpLoads), .count(statLoads));
  lrp_satcount #(.W(STAT_W)) uRed (.clk(clk), .rst_n(rst_n),
    .bump(strobe.bumpRedundant), .count(statRedundant));
  lrp_satcount #(.W(STAT_W)) uMiss (.clk(clk), .rst_n(rst_n),
    .bump(strobe.bumpMiss), .count(statMispredict));

  // R3: an upward train never lowers the counter
  a_r3_up_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.train && strobe.up) |=> ctrTable[$past(resIdx)] >= $past(ctrTable[resIdx]));
  // R3: a downward train never raises the counter
  a_r3_down_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.train && !strobe.up) |=> ctrTable[$past(resIdx)] <= $past(ctrTable[resIdx]));
  // R7: redundant count never passes the load count
  a_r7_red_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    statRedundant <= statLoads);
endmodule

// File: rtl/load_reuse_predictor.sv
module load_reuse_predictor
  import lrp_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  parameter int DATA_W  = 32,
  parameter int STAT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              predValid,
  input  logic [PC_W-1:0]   predPc,
  input  logic              predHit,
  output logic              predRedundant,
  input  logic              resValid,
  input  logic [PC_W-1:0]   resPc,
  input  logic [DATA_W-1:0] resLoadVal,
  input  logic [DATA_W-1:0] resOldVal,
  input  logic              resPredicted,
  output logic              flushReq,
  output logic [STAT_W-1:0] statLoads,
  output logic [STAT_W-1:0] statRedundant,
  output logic [STAT_W-1:0] statMispredict
);
  lrpStrobe_t strobe;
  logic       predCtrMsb, valueMatch;

  lrp_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n),
    .predValid(predValid), .predHit(predHit), .predCtrMsb(predCtrMsb),
    .resValid(resValid), .resPredicted(resPredicted), .valueMatch(valueMatch),
    .predRedundant(predRedundant), .flushReq(flushReq), .strobe(strobe)
  );

  lrp_datapath #(.ENTRIES(ENTRIES), .PC_W(PC_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) uData (
    .clk(clk), .rst_n(rst_n),
    .predPc(predPc), .resPc(resPc), .resLoadVal(resLoadVal), .resOldVal(resOldVal),
    .strobe(strobe), .predCtrMsb(predCtrMsb), .valueMatch(valueMatch),
    .statLoads(statLoads), .statRedundant(statRedundant), .statMispredict(statMispredict)
  );

  // R6: a not-redundant guess never flushes
  a_r6_no_flush_on_no_guess: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !resPredicted) |-> !flushReq);
  // R5: no guess without a request
  a_r5_idle_predict: assert property (@(posedge clk) disable iff (!rst_n)
    !predValid |-> !predRedundant);
endmodule

// File: tb/sim_load_reuse_predictor.sv
module sim_load_reuse_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int ENT = 64;
  localparam int SW  = 6;          // small statistic width to reach saturation
  localparam int SMAX = (1 << SW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic predValid = 0, predHit = 0, resValid = 0, resPredicted = 0;
  logic [31:0] predPc = 0, resPc = 0, resLoadVal = 0, resOldVal = 0;
  logic predRedundant, flushReq;
  logic [SW-1:0] statLoads, statRedundant, statMispredict;

  int checks = 0, fails = 0;
  int tbl [ENT];
  int nLoads = 0, nRed = 0, nMis = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_reuse_predictor #(.ENTRIES(ENT), .STAT_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .predValid(predValid), .predPc(predPc), .predHit(predHit), .predRedundant(predRedundant),
    .resValid(resValid), .resPc(resPc), .resLoadVal(resLoadVal), .resOldVal(resOldVal),
    .resPredicted(resPredicted), .flushReq(flushReq),
    .statLoads(statLoads), .statRedundant(statRedundant), .statMispredict(statMispredict)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int idxOf(logic [31:0] pc);
    return int'(pc[7:2]);
  endfunction

  // one cycle: inputs already driven at the falling edge
  task automatic cycle();
    bit expPred, expFlush, eq;
    #(CLK_PERIOD/4);
    expPred  = predValid && predHit && (tbl[idxOf(predPc)] >= 2);
    eq       = (resLoadVal == resOldVal);
    expFlush = resValid && resPredicted && !eq;
    check("R5 predRedundant", int'(predRedundant), int'(expPred));
    check("R6 flushReq", int'(flushReq), int'(expFlush));
    check("R7 statLoads", int'(statLoads), nLoads);
    check("R7 statRedundant", int'(statRedundant), nRed);
    check("R7 statMispredict", int'(statMispredict), nMis);
    @(posedge clk);
    if (resValid) begin
      int k = idxOf(resPc);
      if (eq) tbl[k] = (tbl[k] == 3) ? 3 : tbl[k] + 1;
      else    tbl[k] = (tbl[k] == 0) ? 0 : tbl[k] - 1;
      if (nLoads < SMAX) nLoads++;
      if (eq && nRed < SMAX) nRed++;
      if ((resPredicted != eq) && nMis < SMAX) nMis++;
    end
    @(negedge clk);
  endtask

  task automatic drive(bit pv, logic [31:0] pp, bit ph, bit rv, logic [31:0] rp,
                       logic [31:0] lv, logic [31:0] ov, bit rpred);
    predValid = pv; predPc = pp; predHit = ph;
    resValid = rv; resPc = rp; resLoadVal = lv; resOldVal = ov; resPredicted = rpred;
    cycle();
  endtask

  initial begin
    for (int i = 0; i < ENT; i++) tbl[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state, weakly not redundant, stats zero
    drive(1, 32'h40, 1, 0, 0, 0, 0, 0);
    check("R2 reset guess", int'(predRedundant), 0);
    // R3: train up past saturation then down
    for (int i = 0; i < 5; i++) drive(0, 0, 0, 1, 32'h40, 7, 7, 0);
    drive(1, 32'h40, 1, 0, 0, 0, 0, 0);
    check("R3 saturated high guess", int'(predRedundant), 1);
    // R4: cache miss forces not redundant
    drive(1, 32'h40, 0, 0, 0, 0, 0, 0);
    check("R4 miss guess", int'(predRedundant), 0);
    // R1: alias through bit 8 shares the counter
    drive(1, 32'h140, 1, 0, 0, 0, 0, 0);
    check("R1 alias guess", int'(predRedundant), 1);
    // R6: wrong redundant guess flushes; R9: same-cycle predict sees old value
    drive(1, 32'h40, 1, 1, 32'h40, 1, 2, 1);
    drive(1, 32'h40, 1, 1, 32'h40, 1, 2, 1);
    drive(1, 32'h40, 1, 0, 0, 0, 0, 0);
    check("R9 after two downs", int'(predRedundant), 0);
    // R6: not-redundant guess never flushes
    drive(0, 0, 0, 1, 32'h80, 3, 4, 0);
    check("R6 no flush", int'(flushReq), 0);
    // R10: idle resolve carries garbage, nothing moves
    drive(1, 32'h80, 1, 0, 32'h80, 9, 9, 1);
    drive(1, 32'h80, 1, 0, 32'h80, 9, 9, 1);
    // random mix; R8 saturation of the small statistics
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a = $urandom & 32'h1FC;
      logic [31:0] b = $urandom & 32'h1FC;
      drive($urandom_range(0, 1), a, $urandom_range(0, 3) != 0,
            $urandom_range(0, 3) != 0, b, $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1));
    end
    check("R8 loads saturated", int'(statLoads), SMAX);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule